// File: doc/BRIEF.md
# Ethernet Transmit Frame Serializer

This block turns an outgoing Ethernet frame, given one byte at a time, into a bit-serial transmit stream. An upstream source offers bytes on a valid/ready handshake and flags the final byte. The bytes arrive in order: destination address, source address, type field, then payload. The serializer puts a preamble in front of the frame. The preamble is a run of alternating ones and zeros, and it closes with two ones in a row. The serializer then sends each byte least-significant bit first. While it sends, it builds the 32-bit frame check sequence, and at the end it appends the complement of that sequence.

Bit timing comes from a one-cycle `bitEn` strobe. Each strobe moves the serial output on by one bit time. `txEn` frames the whole transmission, from the first preamble bit to the last check bit. A sticky error output reports a frame that grows past the maximum legal length, check bytes included.

Top module: `eth_tx_serializer`

## Requirements
- R1: After reset, `txEn`, `txData`, `inReady` and `oversizeErr` are all low.
- R2: A frame starts only at a `bitEn` cycle in which the block is idle and `inValid` is high. `inReady` stays low while the block is idle and after the byte marked by `inLast` has been taken, until the next frame starts.
- R3: The first 64 bits under `txEn` are the preamble. Bits 0 to 61 alternate and start with 1. Bits 62 and 63 are both 1.
- R4: After the preamble, the accepted bytes follow in acceptance order, each least-significant bit first, one bit per `bitEn`. The first 14 bytes (destination address, source address, type) pass through unaltered.
- R5: The last 32 bits are the bitwise complement of a CRC over all accepted bytes. The CRC uses polynomial 0x04C11DB7 in reflected form and starts from all ones. Bit 0 of the complemented register goes out first. For the nine ASCII bytes "123456789", the appended value read LSB first is 0xCBF43926.
- R6: `txEn` stays high without a gap for exactly 64 + 8·N + 32 bit times for an N-byte frame. It then drops for at least one bit time.
- R7: Once a byte is accepted, `inReady` stays low until all 8 of its bits have been shifted out.
- R8: `oversizeErr` goes high when the accepted byte count plus the 4 check bytes exceeds `MAX_FRAME_BYTES`. It stays high until the next frame starts.
- R9: `txEn` and `txData` change only on clock edges where `bitEn` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | One-cycle strobe per serial bit time |
| inData | input | 8 | Frame byte from upstream |
| inValid | input | 1 | `inData` holds a byte |
| inLast | input | 1 | Current byte is the final frame byte |
| inReady | output | 1 | Block takes the byte at this edge |
| txData | output | 1 | Serial transmit bit |
| txEn | output | 1 | Transmission in progress |
| oversizeErr | output | 1 | Sticky frame-too-long flag |

## Verification
The bench builds the block with `MAX_FRAME_BYTES` set to 24, so the body limit is 20 bytes. With that value, frames of 20 and 21 bytes place the length-error edge on either side of the limit in a few hundred bit times. The preamble length, CRC width and polynomial keep their default values. The standard nine-byte check string therefore gives a known check value, and the frame checks cover the full preamble and start pattern. `bitEn` fires every third clock, which leaves room to confirm that the outputs hold steady between bit times.

// File: rtl/ets_pkg.sv
`timescale 1ns/1ps
package ets_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE,
    PH_DATA,
    PH_CRC,
    PH_GAP
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;      // new frame: preset CRC, clear counters
    logic emitPre;    // drive preamble bit preBit
    logic preBit;
    logic emitData;   // shift one data bit out
    logic emitCrc;    // shift one check bit out
    logic emitIdle;   // drop txEn
    logic allowLoad;  // phase in which bytes may be taken
  } strobe_t;

  // status from datapath to control
  typedef struct packed {
    logic haveByte;   // shift register holds unsent bits
    logic finalBit;   // next data bit is the last bit of the last byte
  } dpStat_t;

endpackage

// File: rtl/ets_ctrl.sv
`timescale 1ns/1ps
module ets_ctrl
  import ets_pkg::*;
#(
  parameter int PRE_BITS  = 64,
  parameter int SYNC_BITS = 2,
  parameter int CRC_W     = 32
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    bitEn,
  input  logic    inValid,
  input  dpStat_t stat,
  output strobe_t strb,
  output phase_t  phase
);

  localparam int CNT_MAX = (PRE_BITS > CRC_W) ? PRE_BITS : CRC_W;
  localparam int CNT_W   = $clog2(CNT_MAX) + 1;
  localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_BITS - 1);
  localparam logic [CNT_W-1:0] SYNC_FROM = CNT_W'(PRE_BITS - SYNC_BITS);
  localparam logic [CNT_W-1:0] CRC_LAST  = CNT_W'(CRC_W - 1);

  phase_t          phaseQ, phaseD;
  logic [CNT_W-1:0] cntQ, cntD;

  always_comb begin
    phaseD = phaseQ;
    cntD   = cntQ;
    strb   = '0;
    unique case (phaseQ)
      PH_IDLE: begin
        if (bitEn && inValid) begin
          strb.start   = 1'b1;
          strb.emitPre = 1'b1;
          strb.preBit  = 1'b1;
          cntD         = CNT_W'(1);
          phaseD       = PH_PRE;
        end
      end
      PH_PRE: begin
        strb.allowLoad = 1'b1;
        if (bitEn) begin
          strb.emitPre = 1'b1;
          strb.preBit  = (cntQ >= SYNC_FROM) ? 1'b1 : ~cntQ[0];
          cntD         = cntQ + CNT_W'(1);
          if (cntQ == PRE_LAST) begin
            phaseD = PH_DATA;
            cntD   = '0;
          end
        end
      end
      PH_DATA: begin
        strb.allowLoad = 1'b1;
        if (bitEn && stat.haveByte) begin
          strb.emitData = 1'b1;
          if (stat.finalBit) begin
            phaseD = PH_CRC;
            cntD   = '0;
          end
        end
      end
      PH_CRC: begin
        if (bitEn) begin
          strb.emitCrc = 1'b1;
          cntD         = cntQ + CNT_W'(1);
          if (cntQ == CRC_LAST) phaseD = PH_GAP;
        end
      end
      PH_GAP: begin
        if (bitEn) begin
          strb.emitIdle = 1'b1;
          phaseD        = PH_IDLE;
        end
      end
      default: phaseD = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      cntQ   <= '0;
    end else begin
      phaseQ <= phaseD;
      cntQ   <= cntD;
    end
  end

  assign phase = phaseQ;

  // phase moves only on bit times
  AST_PHASE_ON_BITEN: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(phaseQ)) else $error("phase moved without bitEn"); // R9

  // no loading while idle
  AST_IDLE_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ == PH_IDLE) |-> !strb.allowLoad) else $error("load enabled while idle"); // R2

  // the check field only starts once the byte buffer has drained
  AST_CRC_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phaseQ == PH_CRC) |-> !stat.haveByte) else $error("crc phase with data pending"); // R5

endmodule

// File: rtl/ets_datapath.sv
`timescale 1ns/1ps
module ets_datapath
  import ets_pkg::*;
#(
  parameter int          DATA_W          = 8,
  parameter int          CRC_W           = 32,
  parameter logic [31:0] CRC_POLY        = 32'h04C11DB7,
  parameter int          MAX_FRAME_BYTES = 1518
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output dpStat_t           stat,
  output logic              txData,
  output logic              txEn,
  output logic              oversizeErr
);

  localparam int BODY_MAX = MAX_FRAME_BYTES - CRC_W / 8;
  localparam int BC_W     = $clog2(MAX_FRAME_BYTES + 1) + 1;
  localparam int BL_W     = $clog2(DATA_W + 1);

  function automatic logic [CRC_W-1:0] reflectPoly(input logic [31:0] p);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = p[CRC_W-1-i];
    return r;
  endfunction

  localparam logic [CRC_W-1:0] POLY_R = reflectPoly(CRC_POLY);

  logic [DATA_W-1:0] shiftQ;
  logic [BL_W-1:0]   bitsLeftQ;
  logic              haveByteQ;
  logic              lastFlagQ;
  logic [CRC_W-1:0]  crcQ;
  logic [BC_W-1:0]   byteCntQ;
  logic              load;
  logic [CRC_W-1:0]  crcNext;

  assign inReady = strb.allowLoad && !haveByteQ && !lastFlagQ;
  assign load    = inReady && inValid;

  assign stat.haveByte = haveByteQ;
  assign stat.finalBit = haveByteQ && lastFlagQ && (bitsLeftQ == BL_W'(1));

  // one reflected CRC step on the bit being sent
  always_comb begin
    crcNext = crcQ >> 1;
    if (crcQ[0] ^ shiftQ[0]) crcNext = crcNext ^ POLY_R;
  end

  // byte buffer and shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftQ    <= '0;
      bitsLeftQ <= '0;
      haveByteQ <= 1'b0;
      lastFlagQ <= 1'b0;
    end else begin
      if (strb.start) lastFlagQ <= 1'b0;
      if (load) begin
        shiftQ    <= inData;
        bitsLeftQ <= BL_W'(DATA_W);
        haveByteQ <= 1'b1;
        lastFlagQ <= inLast;
      end else if (strb.emitData) begin
        shiftQ    <= shiftQ >> 1;
        bitsLeftQ <= bitsLeftQ - BL_W'(1);
        if (bitsLeftQ == BL_W'(1)) haveByteQ <= 1'b0;
      end
    end
  end

  // check-sequence register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      crcQ <= '1;
    end else if (strb.start) begin
      crcQ <= '1;
    end else if (strb.emitData) begin
      crcQ <= crcNext;
    end else if (strb.emitCrc) begin
      crcQ <= crcQ >> 1;
    end
  end

  // length tracking
  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteCntQ    <= '0;
      oversizeErr <= 1'b0;
    end else if (strb.start) begin
      byteCntQ    <= '0;
      oversizeErr <= 1'b0;
    end else if (load) begin
      if (byteCntQ != '1) byteCntQ <= byteCntQ + BC_W'(1);
      if (byteCntQ >= BC_W'(BODY_MAX)) oversizeErr <= 1'b1;
    end
  end

  // serial output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      txData <= 1'b0;
      txEn   <= 1'b0;
    end else if (strb.emitPre) begin
      txData <= strb.preBit;
      txEn   <= 1'b1;
    end else if (strb.emitData) begin
      txData <= shiftQ[0];
    end else if (strb.emitCrc) begin
      txData <= ~crcQ[0];
    end else if (strb.emitIdle) begin
      txData <= 1'b0;
      txEn   <= 1'b0;
    end
  end

  AST_OUT_ON_BITEN: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txEn) && $stable(txData)) else $error("output moved between bit times"); // R9

  AST_BUF_EMPTIES_ON_BITEN: assert property (@(posedge clk) disable iff (!rstN)
    $fell(haveByteQ) |-> $past(bitEn)) else $error("byte buffer drained off a bit time"); // R7

  AST_NO_LOAD_OVER_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    haveByteQ && !strb.emitData |=> $stable(shiftQ)) else $error("pending byte overwritten"); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    oversizeErr && !strb.start |=> oversizeErr) else $error("oversize flag cleared mid-frame"); // R8

endmodule

// File: rtl/eth_tx_serializer.sv
`timescale 1ns/1ps
module eth_tx_serializer
  import ets_pkg::*;
#(
  parameter int          DATA_W          = 8,
  parameter int          PRE_BITS        = 64,
  parameter int          SYNC_BITS       = 2,
  parameter int          CRC_W           = 32,
  parameter logic [31:0] CRC_POLY        = 32'h04C11DB7,
  parameter int          MAX_FRAME_BYTES = 1518
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitEn,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              txData,
  output logic              txEn,
  output logic              oversizeErr
);

  strobe_t strb;
  dpStat_t stat;
  phase_t  phase;

  ets_ctrl #(
    .PRE_BITS (PRE_BITS),
    .SYNC_BITS(SYNC_BITS),
    .CRC_W    (CRC_W)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .bitEn  (bitEn),
    .inValid(inValid),
    .stat   (stat),
    .strb   (strb),
    .phase  (phase)
  );

  ets_datapath #(
    .DATA_W         (DATA_W),
    .CRC_W          (CRC_W),
    .CRC_POLY       (CRC_POLY),
    .MAX_FRAME_BYTES(MAX_FRAME_BYTES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .bitEn      (bitEn),
    .strb       (strb),
    .inData     (inData),
    .inValid    (inValid),
    .inLast     (inLast),
    .inReady    (inReady),
    .stat       (stat),
    .txData     (txData),
    .txEn       (txEn),
    .oversizeErr(oversizeErr)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !txEn && !inReady) else $error("activity while idle"); // R2

  AST_TXEN_DROP_AFTER_CRC: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txEn) |-> $past(phase) == PH_GAP) else $error("txEn dropped before check field ended"); // R6

endmodule

// File: tb/eth_tx_serializer_tb.sv
`timescale 1ns/1ps
module eth_tx_serializer_tb;

  localparam int MAXF = 24;
  localparam int DIV  = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0;
  logic       bitEn = 1'b0;
  logic [7:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady, txData, txEn, oversizeErr;

  eth_tx_serializer #(.MAX_FRAME_BYTES(MAXF)) u_dut (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .txData(txData), .txEn(txEn),
    .oversizeErr(oversizeErr)
  );

  // len, first byte, step
  localparam int VEC [0:4][0:2] = '{
    '{14, 8'h00, 1}, '{15, 8'hFF, 8'h35}, '{16, 8'h00, 0},
    '{17, 8'hA5, 0}, '{19, 8'h01, 8'h02}
  };

  int  vectors = 0, fails = 0;
  bit  cap [0:1023];
  int  capLen = 0;
  bit  inFrame = 0, frameEnded = 0, sampleNow = 0;
  int  divCnt = 0, accepts = 0, stableErrs = 0, readyErrs = 0, cycles = 0;
  logic lastEn = 0, lastData = 0;
  logic [7:0] frm [0:63];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  // bit-time generator and serial monitor
  always @(negedge clk) begin
    cycles++;
    if (sampleNow) begin
      if (txEn) begin
        if (!inFrame) begin inFrame = 1; capLen = 0; end
        if (capLen < 1024) cap[capLen] = txData;
        capLen++;
      end else if (inFrame) begin
        inFrame = 0; frameEnded = 1;
      end
    end else if (rstN) begin
      if (txEn !== lastEn || txData !== lastData) stableErrs++;
    end
    lastEn = txEn; lastData = txData;
    if (rstN && inFrame && inReady && accepts > 0 && (capLen - 64) != 8 * accepts) readyErrs++;
    divCnt = (divCnt == DIV - 1) ? 0 : divCnt + 1;
    bitEn = (divCnt == 0);
    sampleNow = bitEn;
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      chk(0, "WDOG", "watchdog expired", cycles, 150000);
      finishRun();
    end
  end

  task automatic sendFrame(input int n);
    accepts = 0;
    frameEnded = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      inData = frm[i]; inValid = 1; inLast = (i == n - 1);
      #1;
      while (!inReady) begin @(negedge clk); #1; end
      @(posedge clk);
      accepts++;
    end
    @(negedge clk);
    inValid = 0; inLast = 0;
    while (!frameEnded) @(negedge clk);
  endtask

  task automatic checkFrame(input int n, input string tag);
    logic [31:0] c;
    logic [63:0] preAct, preExp;
    logic [31:0] fcsAct;
    int dataBad;
    chk(capLen == 64 + 8 * n + 32, "R6", {tag, " txEn length"}, capLen, 64 + 8 * n + 32);
    preAct = '0; preExp = '0;
    for (int i = 0; i < 64; i++) begin
      preAct[i] = cap[i];
      preExp[i] = (i >= 62) ? 1'b1 : ((i % 2) == 0);
    end
    chk(preAct == preExp, "R3", {tag, " preamble"}, preAct, preExp);
    dataBad = 0;
    c = '1;
    for (int b = 0; b < n; b++) begin
      for (int k = 0; k < 8; k++) begin
        if (cap[64 + 8 * b + k] !== frm[b][k]) dataBad++;
        if (c[0] ^ frm[b][k]) c = (c >> 1) ^ 32'hEDB88320;
        else c = c >> 1;
      end
    end
    chk(dataBad == 0, "R4", {tag, " data bits"}, dataBad, 0);
    fcsAct = '0;
    for (int k = 0; k < 32; k++) fcsAct[k] = cap[64 + 8 * n + k];
    chk(fcsAct == ~c, "R5", {tag, " check field"}, fcsAct, ~c);
    chk(readyErrs == 0, "R7", {tag, " ready while byte pending"}, readyErrs, 0);
    chk(inReady == 1'b0 && txEn == 1'b0, "R2", {tag, " quiet after frame"}, {inReady, txEn}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(txEn == 0 && txData == 0 && inReady == 0 && oversizeErr == 0, "R1", "reset outputs",
        {txEn, txData, inReady, oversizeErr}, 0);
    rstN = 1;
    repeat (10) @(negedge clk);
    chk(txEn == 0 && inReady == 0, "R2", "idle without valid", {txEn, inReady}, 0);

    // table-driven frames
    for (int v = 0; v < 5; v++) begin
      for (int i = 0; i < VEC[v][0]; i++) frm[i] = 8'(VEC[v][1] + i * VEC[v][2]);
      sendFrame(VEC[v][0]);
      checkFrame(VEC[v][0], $sformatf("vec%0d", v));
      chk(oversizeErr == 0, "R8", "legal frame no error", oversizeErr, 0);
    end

    // known check value on "123456789"
    for (int i = 0; i < 9; i++) frm[i] = 8'h31 + 8'(i);
    sendFrame(9);
    checkFrame(9, "ascii");
    begin
      logic [31:0] f;
      for (int k = 0; k < 32; k++) f[k] = cap[64 + 72 + k];
      chk(f == 32'hCBF43926, "R5", "known check value", f, 32'hCBF43926);
    end

    // oversize: 21 body bytes + 4 > 24
    for (int i = 0; i < 21; i++) frm[i] = 8'h5A ^ 8'(i);
    sendFrame(21);
    checkFrame(21, "over");
    chk(oversizeErr == 1, "R8", "21-byte body flags error, held after frame", oversizeErr, 1);

    // exactly at the limit: error clears at start and stays low
    for (int i = 0; i < 20; i++) frm[i] = 8'hC3 + 8'(i);
    sendFrame(20);
    checkFrame(20, "limit");
    chk(oversizeErr == 0, "R8", "20-byte body no error", oversizeErr, 0);

    chk(stableErrs == 0, "R9", "outputs steady between bit times", stableErrs, 0);
    finishRun();
  end

endmodule